// File: doc/BRIEF.md
# Two-Write, Multi-Read Memory with RAM-Held Last-Writer Tracking

This block presents a memory with two write ports and a parameterised number of read ports. It is built only from simple RAM primitives that each have one write port and one read port. Each write port owns a data bank, and that bank holds one RAM copy for every read port. A read port therefore reads every bank at its own address, with no contention against the other ports. The block then picks the bank whose write port touched that address last.

The last writer is tracked in one single-bit RAM per write port, not in a register array, so the tracking cost grows with depth like any other RAM. A write through port 0 stores the tracking bit of port 1 at that address. A write through port 1 stores the complement of port 0's bit. This invalidates whatever the other port recorded. The XOR of the two bits then names the last writer. Each tracking RAM is copied once for the other port's write-time lookup, which is an asynchronous read, and once per read port, which is a registered read. Read data appears a fixed number of cycles after the address, set by a latency parameter.

Top module: `lw_mpram`

## Requirements
- R1: While `rst_ni` is low, every read data output is zero (with `RD_LAT` of 2 or more).
- R2: A value written to an address is returned on a read port whose address is presented in a later cycle, `RD_LAT` cycles after that address is presented.
- R3: When both write ports write one address in different cycles, a later read returns the value of the most recent write, whichever port made it.
- R4: A read presented in the same cycle as a write to the same address returns the contents from before that write.
- R5: When both write ports write the same address in one cycle, port 1's data is stored and port 1 is recorded as the last writer, so a later write by port 0 to that address is again returned.
- R6: The read ports work independently: different read ports given different addresses in the same cycle each return the contents of their own address.
- R7: A write changes only its own address; the other addresses keep their contents.
- R8: A write port whose enable bit is 0 changes no location, whatever its address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 2 | Write enable, bit k for write port k |
| wr_addr_i | input | 2 x AW | Write address per write port, AW = clog2(DEPTH) |
| wr_data_i | input | 2 x WIDTH | Write data per write port |
| rd_addr_i | input | NRD x AW | Read address per read port |
| rd_data_o | output | NRD x WIDTH | Read data per read port, RD_LAT cycles after its address |

## Verification
The hardest case to reach from the ports is a tracking entry that was last changed by a same-cycle collision. The next write by the losing port must then flip the XOR back, even though that port's own entry was never updated. The directed table builds this case on purpose. It sends a collision, then a lone port-0 write to the same address, then reads from both ports. A random phase then mixes both write ports over a small address window, so that collisions, reads during writes and port alternation at one address recur often. Every read is compared against a reference map.

// File: rtl/lw_mpram_pkg.sv
package lw_mpram_pkg;
  // number of write ports the XOR tracking scheme supports
  localparam int unsigned WR_PORTS = 2;
  // write port that wins a same-address collision
  localparam int unsigned WIN_PORT = 1;
endpackage

// File: rtl/lw_dpram.sv
// Behavioural simple dual-port RAM: one write port, one read port.
// SYNC_RD selects a registered read (1 cycle) or an asynchronous read.
module lw_dpram #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned WIDTH   = 8,
  parameter bit          SYNC_RD = 1'b1,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  generate
    if (SYNC_RD) begin : g_sync
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk) begin
        q <= mem[raddr];
      end
      assign rdata = q;
    end else begin : g_async
      assign rdata = mem[raddr];
    end
  endgenerate
endmodule

// File: rtl/lw_track_bank.sv
// One write port's last-writer bit, replicated: one asynchronous copy for
// the other write port's lookup and one registered copy per read port.
module lw_track_bank #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned NRD   = 2,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic                    wbit,
  input  logic [AW-1:0]           look_addr,
  output logic                    look_bit,
  input  logic [NRD-1:0][AW-1:0]  rd_addr,
  output logic [NRD-1:0]          rd_bit
);
  lw_dpram #(.DEPTH(DEPTH), .WIDTH(1), .SYNC_RD(1'b0)) u_look (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wbit),
    .raddr (look_addr),
    .rdata (look_bit)
  );

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    lw_dpram #(.DEPTH(DEPTH), .WIDTH(1), .SYNC_RD(1'b1)) u_copy (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wbit),
      .raddr (rd_addr[r]),
      .rdata (rd_bit[r])
    );
  end
endmodule

// File: rtl/lw_data_bank.sv
// One write port's data, replicated once per read port.
module lw_data_bank #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 16,
  parameter int unsigned NRD   = 2,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [WIDTH-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0]    rd_addr,
  output logic [NRD-1:0][WIDTH-1:0] rd_data
);
  for (genvar r = 0; r < NRD; r++) begin : g_rd
    lw_dpram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SYNC_RD(1'b1)) u_copy (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (rd_addr[r]),
      .rdata (rd_data[r])
    );
  end
endmodule

// File: rtl/lw_mpram.sv
// Two write ports, NRD read ports, last writer tracked in RAM by XOR bits.
module lw_mpram
  import lw_mpram_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned NRD    = 2,
  parameter int unsigned RD_LAT = 2,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_ni,
  input  logic [WR_PORTS-1:0]           wr_en_i,
  input  logic [WR_PORTS-1:0][AW-1:0]   wr_addr_i,
  input  logic [WR_PORTS-1:0][WIDTH-1:0] wr_data_i,
  input  logic [NRD-1:0][AW-1:0]        rd_addr_i,
  output logic [NRD-1:0][WIDTH-1:0]     rd_data_o
);
  // ---------------- reset: async assert, sync release ----------------
  logic [1:0] rst_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_q[1];

  // ---------------- write side: collision rule ----------------
  logic                collide;
  logic [WR_PORTS-1:0] we_eff;
  logic [WR_PORTS-1:0] look_bit;
  logic [WR_PORTS-1:0] trk_wbit;

  always_comb begin
    collide = wr_en_i[0] && wr_en_i[1] && (wr_addr_i[0] == wr_addr_i[1]);
    // the losing port is fully suppressed so tracking names the winner
    we_eff[WIN_PORT]     = wr_en_i[WIN_PORT];
    we_eff[1 - WIN_PORT] = wr_en_i[1 - WIN_PORT] && !collide;
    // port 0 copies port 1's bit, port 1 stores the inverse of port 0's bit
    trk_wbit[0] = look_bit[1];
    trk_wbit[1] = ~look_bit[0];
  end

  // ---------------- banks ----------------
  logic [NRD-1:0][WIDTH-1:0] bank_q [WR_PORTS];
  logic [NRD-1:0]            trk_q  [WR_PORTS];

  for (genvar k = 0; k < WR_PORTS; k++) begin : g_wp
    lw_data_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NRD(NRD)) u_data (
      .clk     (clk),
      .we      (we_eff[k]),
      .waddr   (wr_addr_i[k]),
      .wdata   (wr_data_i[k]),
      .rd_addr (rd_addr_i),
      .rd_data (bank_q[k])
    );

    // bank k is looked up at the other port's write address
    lw_track_bank #(.DEPTH(DEPTH), .NRD(NRD)) u_trk (
      .clk       (clk),
      .we        (we_eff[k]),
      .waddr     (wr_addr_i[k]),
      .wbit      (trk_wbit[k]),
      .look_addr (wr_addr_i[1 - k]),
      .look_bit  (look_bit[k]),
      .rd_addr   (rd_addr_i),
      .rd_bit    (trk_q[k])
    );
  end

  // ---------------- read steering ----------------
  logic [NRD-1:0]            rd_sel;
  logic [NRD-1:0][WIDTH-1:0] rd_mux;

  always_comb begin
    for (int r = 0; r < NRD; r++) begin
      rd_sel[r] = trk_q[0][r] ^ trk_q[1][r];
      rd_mux[r] = rd_sel[r] ? bank_q[1][r] : bank_q[0][r];
    end
  end

  // ---------------- output latency stages ----------------
  generate
    if (RD_LAT > 1) begin : g_pipe
      localparam int unsigned NSTG = RD_LAT - 1;
      logic [NRD-1:0][WIDTH-1:0] pipe_d [NSTG];
      logic [NRD-1:0][WIDTH-1:0] pipe_q [NSTG];

      always_comb begin
        pipe_d[0] = rd_mux;
        for (int s = 1; s < int'(NSTG); s++) begin
          pipe_d[s] = pipe_q[s-1];
        end
      end

      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) begin
          for (int s = 0; s < int'(NSTG); s++) begin
            pipe_q[s] <= '0;
          end
        end else begin
          for (int s = 0; s < int'(NSTG); s++) begin
            pipe_q[s] <= pipe_d[s];
          end
        end
      end
      assign rd_data_o = pipe_q[NSTG-1];
    end else begin : g_direct
      assign rd_data_o = rd_mux;
    end
  endgenerate
endmodule

// File: rtl/lw_mpram_chk.sv
// Property checker for lw_mpram, attached by bind.
module lw_mpram_chk #(
  parameter int unsigned NRD    = 2,
  parameter int unsigned AW     = 6,
  parameter int unsigned W      = 16,
  parameter int unsigned RD_LAT = 2
) (
  input logic                   clk,
  input logic                   rst_ni,
  input logic [1:0]             wr_en,
  input logic [1:0][AW-1:0]     wr_addr,
  input logic [1:0][W-1:0]      wr_data,
  input logic [NRD-1:0][AW-1:0] rd_addr,
  input logic [NRD-1:0]         sel,
  input logic [NRD-1:0][W-1:0]  mux_q,
  input logic [NRD-1:0][W-1:0]  rd_data
);
  logic [1:0] won;
  logic       clash;
  always_comb begin
    clash  = wr_en[0] && wr_en[1] && (wr_addr[0] == wr_addr[1]);
    won[1] = wr_en[1];
    won[0] = wr_en[0] && !clash;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_r
    for (genvar k = 0; k < 2; k++) begin : g_k
      // R3: the tracking steers to the port that wrote the address last
      assert_last_writer_R3: assert property (@(posedge clk) disable iff (!rst_ni)
        ($past(won[k]) && rd_addr[r] == $past(wr_addr[k])) |=> sel[r] == k);
      // R2: the steered data is the value written
      assert_fresh_data_R2: assert property (@(posedge clk) disable iff (!rst_ni)
        ($past(won[k]) && rd_addr[r] == $past(wr_addr[k])) |=> mux_q[r] == $past(wr_data[k], 2));
    end
    // R5: a same-address collision leaves port 1's data
    assert_collide_win_R5: assert property (@(posedge clk) disable iff (!rst_ni)
      ($past(clash) && rd_addr[r] == $past(wr_addr[1])) |=> mux_q[r] == $past(wr_data[1], 2));
  end

  if (RD_LAT > 1) begin : g_rst
    // R1: outputs are cleared while reset is held
    assert_reset_zero_R1: assert property (@(posedge clk)
      !rst_ni |=> rd_data == '0);
  end
endmodule

bind lw_mpram lw_mpram_chk #(
  .NRD(NRD), .AW(AW), .W(WIDTH), .RD_LAT(RD_LAT)
) chk_i (
  .clk     (clk),
  .rst_ni  (rst_ni),
  .wr_en   (wr_en_i),
  .wr_addr (wr_addr_i),
  .wr_data (wr_data_i),
  .rd_addr (rd_addr_i),
  .sel     (rd_sel),
  .mux_q   (rd_mux),
  .rd_data (rd_data_o)
);

// File: tb/lw_mpram_tb_top.sv
`timescale 1ns/1ps
module lw_mpram_tb_top;
  localparam int DEPTH = 64;
  localparam int WIDTH = 16;
  localparam int NRD   = 2;
  localparam int AW    = 6;
  localparam int NRAND = 1500;

  logic                      clk;
  logic                      rst_ni;
  logic [1:0]                wr_en_i;
  logic [1:0][AW-1:0]        wr_addr_i;
  logic [1:0][WIDTH-1:0]     wr_data_i;
  logic [NRD-1:0][AW-1:0]    rd_addr_i;
  logic [NRD-1:0][WIDTH-1:0] rd_data_o;

  lw_mpram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NRD(NRD), .RD_LAT(2)) dut_i (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic check(input string req, input int tag, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (item %0d): actual %h expected %h", req, tag, act, exp);
    end
  endtask

  // directed vectors; a read result is checked two cycles after its address
  typedef struct packed {
    logic          we0; logic [AW-1:0] a0; logic [WIDTH-1:0] d0;
    logic          we1; logic [AW-1:0] a1; logic [WIDTH-1:0] d1;
    logic [AW-1:0] r0;  logic [AW-1:0] r1;
    logic          c0;  logic          c1;
    logic [WIDTH-1:0] e0; logic [WIDTH-1:0] e1;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 6'd1, 16'h1111, 1'b1, 6'd2, 16'h2222, 6'd0, 6'd0, 1'b0, 1'b0, 16'h0,    16'h0,    4'd2}, // R2 writes
    '{1'b0, 6'd0, 16'h0,    1'b0, 6'd0, 16'h0,    6'd1, 6'd2, 1'b1, 1'b1, 16'h1111, 16'h2222, 4'd6}, // R6
    '{1'b0, 6'd0, 16'h0,    1'b1, 6'd1, 16'h3333, 6'd1, 6'd2, 1'b1, 1'b1, 16'h1111, 16'h2222, 4'd4}, // R4
    '{1'b1, 6'd1, 16'h4444, 1'b0, 6'd0, 16'h0,    6'd1, 6'd1, 1'b1, 1'b1, 16'h3333, 16'h3333, 4'd3}, // R3
    '{1'b0, 6'd0, 16'h0,    1'b0, 6'd0, 16'h0,    6'd1, 6'd2, 1'b1, 1'b1, 16'h4444, 16'h2222, 4'd7}, // R7
    '{1'b1, 6'd3, 16'hAAAA, 1'b1, 6'd3, 16'hBBBB, 6'd0, 6'd0, 1'b0, 1'b0, 16'h0,    16'h0,    4'd5}, // R5 clash
    '{1'b0, 6'd0, 16'h0,    1'b0, 6'd0, 16'h0,    6'd3, 6'd3, 1'b1, 1'b1, 16'hBBBB, 16'hBBBB, 4'd5}, // R5
    '{1'b1, 6'd3, 16'hCCCC, 1'b0, 6'd3, 16'hDDDD, 6'd0, 6'd0, 1'b0, 1'b0, 16'h0,    16'h0,    4'd8}, // R8
    '{1'b0, 6'd0, 16'h0,    1'b0, 6'd0, 16'h0,    6'd3, 6'd3, 1'b1, 1'b1, 16'hCCCC, 16'hCCCC, 4'd8}, // R8
    '{1'b0, 6'd2, 16'hEEEE, 1'b0, 6'd1, 16'hFFFF, 6'd0, 6'd0, 1'b0, 1'b0, 16'h0,    16'h0,    4'd8}, // R8
    '{1'b0, 6'd0, 16'h0,    1'b0, 6'd0, 16'h0,    6'd2, 6'd1, 1'b1, 1'b1, 16'h2222, 16'h4444, 4'd8}, // R8
    '{1'b1, 6'd4, 16'h0101, 1'b1, 6'd4, 16'h0202, 6'd0, 6'd0, 1'b0, 1'b0, 16'h0,    16'h0,    4'd5}, // R5 clash
    '{1'b1, 6'd4, 16'h0303, 1'b0, 6'd0, 16'h0,    6'd4, 6'd0, 1'b1, 1'b0, 16'h0202, 16'h0,    4'd5}, // R5
    '{1'b0, 6'd0, 16'h0,    1'b0, 6'd0, 16'h0,    6'd4, 6'd4, 1'b1, 1'b1, 16'h0303, 16'h0303, 4'd5}  // R5
  };

  task automatic idle();
    wr_en_i   = 2'b00;
    wr_addr_i = '0;
    wr_data_i = '0;
    rd_addr_i = '0;
  endtask

  task automatic next_cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string rtag(input logic [3:0] n);
    return $sformatf("R%0d", n);
  endfunction

  // random phase state
  logic [WIDTH-1:0] ref_mem [int];
  logic [WIDTH-1:0] rexp0 [NRAND];
  logic [WIDTH-1:0] rexp1 [NRAND];
  bit               rv0   [NRAND];
  bit               rv1   [NRAND];

  initial begin
    idle();
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    // R1: outputs held at zero during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1", i, rd_data_o[0], '0);
      check("R1", i, rd_data_o[1], '0);
    end
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) next_cycle();

    // directed table walk
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) begin
        if (VEC[i-2].c0) check(rtag(VEC[i-2].rq), i - 2, rd_data_o[0], VEC[i-2].e0);
        if (VEC[i-2].c1) check(rtag(VEC[i-2].rq), i - 2, rd_data_o[1], VEC[i-2].e1);
      end
      if (i < NV) begin
        wr_en_i      = {VEC[i].we1, VEC[i].we0};
        wr_addr_i[0] = VEC[i].a0;
        wr_data_i[0] = VEC[i].d0;
        wr_addr_i[1] = VEC[i].a1;
        wr_data_i[1] = VEC[i].d1;
        rd_addr_i[0] = VEC[i].r0;
        rd_addr_i[1] = VEC[i].r1;
      end else begin
        idle();
      end
      next_cycle();
    end

    // random concurrent traffic on addresses 16..31 against a reference map (R3)
    for (int i = 0; i < NRAND + 2; i++) begin
      if (i >= 2) begin
        if (rv0[i-2]) check("R3", i - 2, rd_data_o[0], rexp0[i-2]);
        if (rv1[i-2]) check("R3", i - 2, rd_data_o[1], rexp1[i-2]);
      end
      if (i < NRAND) begin
        logic [AW-1:0] a0, a1, q0, q1;
        logic          w0, w1;
        logic [WIDTH-1:0] d0, d1;
        a0 = AW'(16 + $urandom_range(0, 15));
        a1 = AW'(16 + $urandom_range(0, 15));
        q0 = AW'(16 + $urandom_range(0, 15));
        q1 = AW'(16 + $urandom_range(0, 15));
        w0 = 1'($urandom_range(0, 1));
        w1 = 1'($urandom_range(0, 1));
        d0 = WIDTH'($urandom);
        d1 = WIDTH'($urandom);
        rv0[i] = ref_mem.exists(int'(q0));
        rv1[i] = ref_mem.exists(int'(q1));
        rexp0[i] = rv0[i] ? ref_mem[int'(q0)] : '0;
        rexp1[i] = rv1[i] ? ref_mem[int'(q1)] : '0;
        if (w0 && !(w1 && a0 == a1)) ref_mem[int'(a0)] = d0;
        if (w1) ref_mem[int'(a1)] = d1;
        wr_en_i      = {w1, w0};
        wr_addr_i[0] = a0;
        wr_addr_i[1] = a1;
        wr_data_i[0] = d0;
        wr_data_i[1] = d1;
        rd_addr_i[0] = q0;
        rd_addr_i[1] = q1;
      end else begin
        idle();
      end
      next_cycle();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule